// File: doc/BRIEF.md
# Lane Divergence Mask Stack

This block tracks which lanes of a 32-wide SIMD thread group may commit results while the group walks through nested conditional code. Every lane runs both sides of a branch; the block produces an active-lane mask and the lanes use it as a write enable for their results.

The instruction stream supplies three markers alongside a per-lane predicate. A push marker (at a divergent branch) saves the current mask on an internal stack and narrows it to the lanes whose predicate is true. A complement marker (at the start of the other side) switches to the lanes that were enabled before the branch but were not on the first side. A pop marker (at the reconvergence point) restores the mask saved by the matching push. The stack holds eight levels of nesting. A push into a full stack and a pop from an empty stack are refused and raise sticky error flags.

All state is registered. A marker sampled at a rising edge shows its effect on the outputs right after that edge.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the stack depth is 0, and both error flags are 0.
- R2: An accepted push stores the current mask as the new top entry, sets the mask to the current mask ANDed with the predicate, and raises the depth by one.
- R3: A complement sets the mask to the top entry ANDed with the inverse of the current mask. With an empty stack the top entry is taken as all ones. Depth is unchanged.
- R4: An accepted pop sets the mask to the top entry and lowers the depth by one.
- R5: A push while the depth is 8 leaves mask and depth unchanged and sets the overflow flag.
- R6: A pop while the depth is 0 leaves mask and depth unchanged and sets the underflow flag.
- R7: When several markers are high in one cycle, only one acts: push first, then complement, then pop.
- R8: In a cycle with no marker, the mask and the depth hold their values.
- R9: Nested pushes followed by pops restore the saved masks in last-in, first-out order through all 8 levels.
- R10: Once set, an error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Divergent-branch marker: save the mask and narrow it by the predicate |
| cmpl_i | input | 1 | Else-side marker: switch to the complementary lanes |
| pop_i | input | 1 | Reconvergence marker: restore the saved mask |
| pred_i | input | 32 | Per-lane branch predicate, bit n for lane n |
| active_o | output | 32 | Active-lane mask gating each lane's result commit |
| depth_o | output | 4 | Number of saved masks on the stack |
| ovf_o | output | 1 | Sticky flag: a push was refused because the stack was full |
| udf_o | output | 1 | Sticky flag: a pop was refused because the stack was empty |

## Verification
The bench targets the following corner cases:

- **Ninth push and pop on an empty stack.** A design that misses these edges would wrap the pointer and corrupt a saved entry, or return a stale mask.
- **Complement with nothing saved.** An implementation that forgot the all-ones parent would enable no lanes.
- **Complement inside a narrowed region.** A plain inversion would wrongly revive lanes that were disabled further out.
- **Simultaneous markers.** These expose a wrong priority order.
- **Deep nesting with distinct predicates, then full unwinding.** This catches a stack that returns entries out of order or that moves the depth on a refused operation.
- **Reset in the middle of a run.** This shows whether the sticky flags and the stack truly clear.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  localparam int unsigned MAX_LANES = 64;

  // mask for the taken side of a branch
  function automatic logic [MAX_LANES-1:0] taken_mask(
    input logic [MAX_LANES-1:0] cur,
    input logic [MAX_LANES-1:0] pred
  );
    return cur & pred;
  endfunction

  // mask for the other side: lanes enabled at branch time but not on the first side
  function automatic logic [MAX_LANES-1:0] other_mask(
    input logic [MAX_LANES-1:0] parent,
    input logic [MAX_LANES-1:0] cur
  );
    return parent & ~cur;
  endfunction
endpackage

// File: rtl/simt_marker_decode.sv
module simt_marker_decode (
  input  logic push_i,
  input  logic cmpl_i,
  input  logic pop_i,
  input  logic stack_full,
  input  logic stack_empty,
  output logic evt_push,
  output logic evt_cmpl,
  output logic evt_pop,
  output logic evt_ovf,
  output logic evt_udf
);
  logic sel_push, sel_cmpl, sel_pop;

  // fixed priority: push, then complement, then pop
  always_comb begin
    sel_push = push_i;
    sel_cmpl = !push_i && cmpl_i;
    sel_pop  = !push_i && !cmpl_i && pop_i;
  end

  assign evt_push = sel_push && !stack_full;
  assign evt_ovf  = sel_push && stack_full;
  assign evt_cmpl = sel_cmpl;
  assign evt_pop  = sel_pop && !stack_empty;
  assign evt_udf  = sel_pop && stack_empty;
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_idx == IW'(i)) ent[i] <= wr_data;
    end
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             cmpl_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] active_o,
  output logic [PW-1:0]    depth_o,
  output logic             ovf_o,
  output logic             udf_o
);
  import simt_mask_pkg::*;

  logic [LANES-1:0] cur_q;
  logic [PW-1:0]    depth_q;
  logic             ovf_q, udf_q;

  // named internal events, also observed by the checker
  logic stack_full, stack_empty;
  logic evt_push, evt_cmpl, evt_pop, evt_ovf, evt_udf;
  logic [LANES-1:0] top_raw, parent;
  logic [PW-1:0]    depth_m1;
  logic [LANES-1:0] nxt_taken, nxt_other;

  assign stack_full  = (depth_q == PW'(DEPTH));
  assign stack_empty = (depth_q == '0);
  assign depth_m1    = depth_q - 1'b1;

  simt_marker_decode u_dec (
    .push_i      (push_i),
    .cmpl_i      (cmpl_i),
    .pop_i       (pop_i),
    .stack_full  (stack_full),
    .stack_empty (stack_empty),
    .evt_push    (evt_push),
    .evt_cmpl    (evt_cmpl),
    .evt_pop     (evt_pop),
    .evt_ovf     (evt_ovf),
    .evt_udf     (evt_udf)
  );

  simt_stack_store #(.WIDTH(LANES), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (evt_push),
    .wr_idx  (depth_q[IW-1:0]),
    .wr_data (cur_q),
    .rd_idx  (depth_m1[IW-1:0]),
    .rd_data (top_raw)
  );

  // an empty stack acts as if every lane had been enabled outside
  assign parent = stack_empty ? '1 : top_raw;

  always_comb begin
    logic [MAX_LANES-1:0] wide_cur, wide_pred, wide_par, t, o;
    wide_cur  = MAX_LANES'(cur_q);
    wide_pred = MAX_LANES'(pred_i);
    wide_par  = MAX_LANES'(parent);
    t = taken_mask(wide_cur, wide_pred);
    o = other_mask(wide_par, wide_cur);
    nxt_taken = t[LANES-1:0];
    nxt_other = o[LANES-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '1;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      if (evt_push) begin
        cur_q   <= nxt_taken;
        depth_q <= depth_q + 1'b1;
      end else if (evt_cmpl) begin
        cur_q   <= nxt_other;
      end else if (evt_pop) begin
        cur_q   <= parent;
        depth_q <= depth_m1;
      end
      if (evt_ovf) ovf_q <= 1'b1;
      if (evt_udf) udf_q <= 1'b1;
    end
  end

  assign active_o = cur_q;
  assign depth_o  = depth_q;
  assign ovf_o    = ovf_q;
  assign udf_o    = udf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned PW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             cmpl_i,
  input logic             pop_i,
  input logic [LANES-1:0] active_o,
  input logic [PW-1:0]    depth_o,
  input logic             ovf_o,
  input logic             udf_o,
  input logic             evt_push,
  input logic             evt_cmpl,
  input logic             evt_pop,
  input logic             stack_full,
  input logic             stack_empty
);
  a_r2_push_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push |=> ((active_o & ~$past(active_o)) == '0));
  a_r2_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push |=> (depth_o == $past(depth_o) + 1'b1));
  a_r3_cmpl_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmpl |=> (((active_o & $past(active_o)) == '0) && $stable(depth_o)));
  a_r4_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |=> (depth_o == $past(depth_o) - 1'b1));
  a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && stack_full) |=> (ovf_o && $stable(active_o) && $stable(depth_o)));
  a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !cmpl_i && stack_empty) |=> (udf_o && $stable(active_o) && $stable(depth_o)));
  a_r7_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && (cmpl_i || pop_i)) |-> (evt_push || stack_full) && !evt_cmpl && !evt_pop);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !cmpl_i && !pop_i) |=> ($stable(active_o) && $stable(depth_o)));
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  a_r10_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf_o |=> udf_o);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .cmpl_i      (cmpl_i),
  .pop_i       (pop_i),
  .active_o    (active_o),
  .depth_o     (depth_o),
  .ovf_o       (ovf_o),
  .udf_o       (udf_o),
  .evt_push    (evt_push),
  .evt_cmpl    (evt_cmpl),
  .evt_pop     (evt_pop),
  .stack_full  (stack_full),
  .stack_empty (stack_empty)
);

// File: tb/simt_mask_stack_tb.sv
module simt_mask_stack_tb;
  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 1'b0, cmpl_i = 1'b0, pop_i = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic [LANES-1:0] active_o;
  logic [3:0] depth_o;
  logic ovf_o, udf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stack[$];
  bit m_ovf, m_udf;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .cmpl_i(cmpl_i), .pop_i(pop_i),
    .pred_i(pred_i), .active_o(active_o), .depth_o(depth_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  task automatic model_reset();
    m_mask = '1;
    m_stack.delete();
    m_ovf = 0;
    m_udf = 0;
    m_tag = "R1";
  endtask

  task automatic model_step(input bit p, input bit c, input bit o, input logic [LANES-1:0] pr);
    logic [LANES-1:0] par;
    if (p) begin
      if (m_stack.size() == DEPTH) begin m_ovf = 1; m_tag = "R5"; end
      else begin m_stack.push_back(m_mask); m_mask = m_mask & pr; m_tag = "R2"; end
    end else if (c) begin
      par = (m_stack.size() == 0) ? {LANES{1'b1}} : m_stack[$];
      m_mask = par & ~m_mask;
      m_tag = "R3";
    end else if (o) begin
      if (m_stack.size() == 0) begin m_udf = 1; m_tag = "R6"; end
      else begin m_mask = m_stack.pop_back(); m_tag = "R4/R9"; end
    end else m_tag = "R8";
    if (int'(p) + int'(c) + int'(o) > 1) m_tag = {m_tag, "/R7"};
  endtask

  task automatic compare();
    checks++;
    if (active_o !== m_mask || depth_o !== 4'(m_stack.size())) begin
      errors++;
      $display("FAIL %s: mask %h depth %0d, expected mask %h depth %0d",
               m_tag, active_o, depth_o, m_mask, m_stack.size());
    end
    checks++;
    if (ovf_o !== m_ovf || udf_o !== m_udf) begin
      errors++;
      $display("FAIL %s/R10: ovf %b udf %b, expected ovf %b udf %b",
               m_tag, ovf_o, udf_o, m_ovf, m_udf);
    end
  endtask

  // check the state left by the previous cycle, then drive and model the next one
  task automatic cyc(input bit p, input bit c, input bit o, input logic [LANES-1:0] pr);
    @(negedge clk);
    compare();
    push_i = p; cmpl_i = c; pop_i = o; pred_i = pr;
    model_step(p, c, o, pr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    push_i = 0; cmpl_i = 0; pop_i = 0;
    rst_n = 0;
    model_reset();
    @(negedge clk);
    compare();  // R1 reset state
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();

    // R8 idle hold, R3 complement on empty stack, R6 pop on empty
    cyc(0, 0, 0, '0);
    cyc(0, 1, 0, 32'h0000_FFFF);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 1, '0);
    cyc(0, 0, 0, '0);

    // R9 nesting through every level, then R5 ninth push
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, ~(32'h1 << (i * 3)));
    cyc(1, 0, 0, 32'hFFFF_FFFF);
    cyc(0, 1, 0, '0);  // R3 inside narrowed region
    cyc(0, 1, 0, '0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, '0);
    cyc(0, 0, 1, '0);  // R6 again
    cyc(0, 0, 0, '0);

    // R7 simultaneous markers
    cyc(1, 1, 1, 32'hF0F0_F0F0);
    cyc(0, 1, 1, '0);
    cyc(1, 0, 1, 32'h0FF0_0FF0);
    cyc(0, 0, 1, '0);
    cyc(0, 0, 1, '0);

    // R1 mid-run reset clears sticky flags and stack
    do_reset();

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) cyc(1, 0, 0, $urandom);
      else if (r < 5) cyc(0, 1, 0, $urandom);
      else if (r < 8) cyc(0, 0, 1, $urandom);
      else if (r < 9) cyc(0, 0, 0, $urandom);
      else cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1, $urandom);
    end
    @(negedge clk);
    compare();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule